// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block is an N-bit arithmetic/logic unit built from N identical one-bit slices. Each slice forms the bitwise AND and OR of its two operand bits, and the sum bit of a full adder whose second operand can be inverted for subtraction. A 2-bit operation code is shared by every slice and drives a four-way selector in each slice, which picks the slice's result bit.

The carries ripple from slice 0 up to the top slice. The subtract control does two things: it inverts the B operand inside every slice, and it feeds a carry of 1 into slice 0. The carry out of the top slice is corrected by the subtract control. After an addition it is the unsigned carry. After a subtraction it is a borrow, which is 1 exactly when A is below B as unsigned numbers.

The fourth operation places that corrected flag, zero-extended, on the result bus. The same datapath therefore also serves as an unsigned magnitude comparator. The block is purely combinational: it has no clock, no reset and no state.

Top module: `bitslice_alu`

## Requirements
- R1: With op_i = 2'b00 the result equals A AND B bit by bit, whatever the value of sub_i.
- R2: With op_i = 2'b01 the result equals A OR B bit by bit, whatever the value of sub_i.
- R3: With op_i = 2'b10 and sub_i = 0 the result equals (A + B) modulo 2^WIDTH.
- R4: With op_i = 2'b10 and sub_i = 1 the result equals (A - B) modulo 2^WIDTH.
- R5: With sub_i = 0, carry_o equals bit WIDTH of the unsigned sum A + B, for every op_i value.
- R6: With sub_i = 1, carry_o is 1 exactly when A < B as unsigned numbers, for every op_i value.
- R7: With op_i = 2'b11, result bit 0 equals carry_o and every higher result bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| op_i | input | 2 | Operation code: 00 AND, 01 OR, 10 sum/difference, 11 carry/borrow flag |
| sub_i | input | 1 | 1 selects subtraction (B inverted and carry-in of 1) |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Corrected carry (add) or borrow (subtract) out of the top slice |

## Verification
The hardest case to reach is a carry that must ripple through every slice. Examples are all-ones plus one, and subtracting equal or adjacent operands, where the borrow depends on the very last slice. A 4-bit instance is swept over every combination of operands, operation and subtract control, so every ripple length and every A = B and A = B ± 1 pair occurs. A 32-bit instance is driven with pairs drawn from 0, all-ones, the sign boundary and values next to each other.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;
    typedef enum logic [1:0] {
        OP_AND   = 2'b00,
        OP_OR    = 2'b01,
        OP_SUM   = 2'b10,
        OP_CARRY = 2'b11
    } alu_op_e;
endpackage

// File: rtl/bsalu_full_add.sv
module bsalu_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    logic half;
    always_comb begin
        half = x_i ^ y_i;
        s_o  = half ^ c_i;
        c_o  = (x_i & y_i) | (half & c_i);
    end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
    import bsalu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       sub_i,
    input  logic       cin_i,
    input  logic       flag_i,
    input  logic [1:0] op_i,
    output logic       res_o,
    output logic       cout_o
);
    logic    b_eff;
    logic    sum_bit;
    alu_op_e op_sel;

    assign b_eff  = b_i ^ sub_i;
    assign op_sel = alu_op_e'(op_i);

    bsalu_full_add u_fa (
        .x_i (a_i),
        .y_i (b_eff),
        .c_i (cin_i),
        .s_o (sum_bit),
        .c_o (cout_o)
    );

    always_comb begin
        unique case (op_sel)
            OP_AND:   res_o = a_i & b_i;
            OP_OR:    res_o = a_i | b_i;
            OP_SUM:   res_o = sum_bit;
            OP_CARRY: res_o = flag_i;
            default:  res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       op_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);
    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] chain;
    logic             flag;

    assign chain[0] = sub_i;
    assign flag     = chain[WIDTH] ^ sub_i;
    assign carry_o  = flag;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_slice
        logic slice_flag;
        if (gi == 0) begin : g_lsb
            assign slice_flag = flag;
        end else begin : g_upper
            assign slice_flag = 1'b0;
        end
        bsalu_slice u_slice (
            .a_i    (a_i[gi]),
            .b_i    (b_i[gi]),
            .sub_i  (sub_i),
            .cin_i  (chain[gi]),
            .flag_i (slice_flag),
            .op_i   (op_i),
            .res_o  (result_o[gi]),
            .cout_o (chain[gi+1])
        );
    end
endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [1:0]       op_i,
    input logic             sub_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        if (op_i == 2'b00)
            p_and_r1: assert (result_o == (a_i & b_i));
        if (op_i == 2'b01)
            p_or_r2: assert (result_o == (a_i | b_i));
        if (op_i == 2'b10 && !sub_i)
            p_sum_r3: assert (result_o == WIDTH'(a_i + b_i));
        if (op_i == 2'b10 && sub_i)
            p_diff_r4: assert (result_o == WIDTH'(a_i - b_i));
        if (sub_i)
            p_borrow_r6: assert (carry_o == (a_i < b_i));
        if (op_i == 2'b11)
            p_flag_r7: assert (result_o == (carry_o ? ONE : '0));
    end
endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i      (a_i),
    .b_i      (b_i),
    .op_i     (op_i),
    .sub_i    (sub_i),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb;
    localparam int NW = 4;
    localparam int WW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [NW-1:0] na, nb, nres;
    logic [WW-1:0] wa, wb, wres;
    logic [1:0]    nop, wop;
    logic          nsub, wsub, ncar, wcar;

    bitslice_alu #(.WIDTH(NW)) u_dut (
        .a_i(na), .b_i(nb), .op_i(nop), .sub_i(nsub),
        .result_o(nres), .carry_o(ncar)
    );

    bitslice_alu #(.WIDTH(WW)) u_dut_wide (
        .a_i(wa), .b_i(wb), .op_i(wop), .sub_i(wsub),
        .result_o(wres), .carry_o(wcar)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string res_req(input logic [1:0] op, input logic sub);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return sub ? "R4" : "R3";
            default: return "R7";
        endcase
    endfunction

    // Expected model: arithmetic on 64-bit values, masked to width w
    function automatic logic [63:0] exp_flag(input logic [63:0] a, input logic [63:0] b,
                                             input logic sub, input int w);
        logic [64:0] s;
        if (sub) return (a < b) ? 64'd1 : 64'd0;   // R6
        s = {1'b0, a} + {1'b0, b};
        return {63'd0, s[w]};                      // R5
    endfunction

    function automatic logic [63:0] exp_res(input logic [63:0] a, input logic [63:0] b,
                                            input logic [1:0] op, input logic sub, input int w);
        logic [63:0] mask;
        mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        case (op)
            2'b00:   return a & b;
            2'b01:   return a | b;
            2'b10:   return sub ? ((a - b) & mask) : ((a + b) & mask);
            default: return exp_flag(a, b, sub, w);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] corner [6];
        // All-zero inputs: AND of zeros, no carry
        @(posedge clk);
        na = '0; nb = '0; nop = 2'b00; nsub = 1'b0;
        wa = '0; wb = '0; wop = 2'b00; wsub = 1'b0;
        @(negedge clk);
        check("R1 zero", {60'd0, nres}, 64'd0);
        check("R5 zero", {63'd0, ncar}, 64'd0);

        // Exhaustive sweep on the narrow instance
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 2; s++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        @(posedge clk);
                        na = NW'(a); nb = NW'(b); nop = 2'(o); nsub = s[0];
                        @(negedge clk);
                        check(res_req(2'(o), s[0]), {60'd0, nres},
                              exp_res(64'(a), 64'(b), 2'(o), s[0], NW));
                        check(s[0] ? "R6" : "R5", {63'd0, ncar},
                              exp_flag(64'(a), 64'(b), s[0], NW));
                    end
                end
            end
        end

        // Corner pairs on the wide instance (full ripple, A=B, A=B+-1)
        corner[0] = 64'h0;
        corner[1] = 64'hFFFF_FFFF;
        corner[2] = 64'h1;
        corner[3] = 64'h8000_0000;
        corner[4] = 64'h7FFF_FFFF;
        corner[5] = 64'h1234_5678;
        for (int i = 0; i < 6; i++) begin
            for (int d = 0; d < 9; d++) begin
                logic [63:0] av, bv;
                av = corner[i];
                if (d < 6)       bv = corner[d];
                else if (d == 6) bv = av;
                else if (d == 7) bv = (av + 64'd1) & 64'hFFFF_FFFF;
                else             bv = (av - 64'd1) & 64'hFFFF_FFFF;
                for (int o = 0; o < 4; o++) begin
                    for (int s = 0; s < 2; s++) begin
                        @(posedge clk);
                        wa = av[31:0]; wb = bv[31:0]; wop = 2'(o); wsub = s[0];
                        @(negedge clk);
                        check(res_req(2'(o), s[0]), {32'd0, wres},
                              exp_res(av, bv, 2'(o), s[0], WW));
                        check(s[0] ? "R6" : "R5", {63'd0, wcar},
                              exp_flag(av, bv, s[0], WW));
                    end
                end
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule